// File: doc/BRIEF.md
# Synthesizer Channel Power and Mode Controller

This block sits between the serial configuration latches of a dual-loop frequency synthesizer and the analog sections of its two channels: channel 0 is the IF loop and channel 1 is the RF loop. Each channel gets a small power state machine. It turns the latched power-down and charge-pump tristate bits into a charge-pump tristate, a divider load-state force and an input debias.

A power-down request takes one of two routes. If the channel's tristate bit was clear before the request, the charge pump is tristated for one clock before the power-down lands. If the tristate bit was already set, the power-down lands at the latch edge itself.

A shared mode register selects what the status pin shows:

- a constant low;
- the lock state of one loop or of both loops;
- a counter-reset mode for one channel or for both;
- a fastlock mode, in which the pin follows the RF fastlock state.

Each channel's fastlock gain bit selects maximum charge-pump current. A dedicated switch output follows the RF gain bit. The reference oscillator runs unless both channels are powered down.

Power states per channel:

- `PWR_ON`: normal operation.
- `PWR_TRI`: the synchronous first step, with the charge pump tristated and power not yet removed.
- `PWR_DOWN`: powered down.

Transitions:

- `ON->TRI`: power-down write while the stored tristate bit is 0.
- `ON->DOWN`: power-down write while the stored tristate bit is 1.
- `TRI->DOWN`: automatic on the next clock.
- `TRI->ON` and `DOWN->ON`: a power-up write.

Mode register states are `MUX_LOW`, `MUX_IF_LOCK`, `MUX_RF_LOCK`, `MUX_BOTH_LOCK`, `MUX_IF_CRST`, `MUX_RF_CRST`, `MUX_BOTH_CRST` and `MUX_FAST`. Any mode write moves the register to the written state.

Top module: `syn_chan_ctrl`

## Requirements
- R1: After reset both channels are in `PWR_DOWN`, so `div_load`, `debias` and `cp_tri` are 2'b11 and `ref_osc_en` is 0. The stored tristate and gain bits are 0, the mode is 0 (`MUX_LOW`), and `cnt_rst`, `cp_max`, `fl_sw` and `mux_out` are 0.
- R2: A write with `cfg_wr[c]`=1 and `cfg_pd[c]`=1 to a powered-on channel whose stored tristate bit is 0 has two steps. After that clock edge `cp_tri[c]`=1 while `div_load[c]` and `debias[c]` stay 0. After the following edge `div_load[c]` and `debias[c]` are 1.
- R3: The same power-down write to a powered-on channel whose stored tristate bit (from an earlier write) is 1 sets `div_load[c]` and `debias[c]` right after the write edge.
- R4: A write with `cfg_pd[c]`=0 returns the channel to `PWR_ON` at that edge, from `PWR_DOWN` and also from `PWR_TRI`. `div_load[c]` and `debias[c]` drop, and `cp_tri[c]` then follows the newly stored tristate bit, ORed with counter reset.
- R5: `ref_osc_en` is 0 exactly when both channels are in `PWR_DOWN`.
- R6: Mode 4 holds channel 0 in counter reset and mode 5 holds channel 1. Mode 6 holds both. A channel in counter reset has `cnt_rst[c]`=1 and `cp_tri[c]`=1, and `mux_out`=0.
- R7: `gain_wr[c]` stores `gain_bit[c]`, and `cp_max[c]` follows the stored bit. `fl_sw` follows the stored RF (channel 1) gain bit, and in mode 7 `mux_out` shows it too.
- R8: `mux_out` is `lock_in[0]` in mode 1 and `lock_in[1]` in mode 2. It is the AND of both in mode 3, and 0 in mode 0.
- R9: A write to one channel's configuration leaves the other channel's power state and tristate bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 2 | Per-channel power/tristate latch strobe |
| cfg_pd | input | 2 | Power-down bit for each channel |
| cfg_tri | input | 2 | Charge-pump tristate bit for each channel |
| gain_wr | input | 2 | Per-channel gain latch strobe |
| gain_bit | input | 2 | Fastlock gain bit for each channel |
| mode_wr | input | 1 | Mode register strobe |
| mode_sel | input | 3 | Mode value (0 to 7) |
| lock_in | input | 2 | Per-channel lock indication |
| cnt_rst | output | 2 | Counter reset for each channel |
| div_load | output | 2 | Force R and AB dividers to their load state |
| cp_tri | output | 2 | Charge-pump tristate |
| cp_max | output | 2 | Select maximum charge-pump current |
| debias | output | 2 | Debias the channel input section |
| ref_osc_en | output | 1 | Reference oscillator enable |
| fl_sw | output | 1 | Fastlock damping-resistor switch |
| mux_out | output | 1 | Multiplexed status pin |

## Verification
Two functions can claim `cp_tri` in the same cycle: counter-reset mode, and the intermediate tristate step of a synchronous power-down. The bench writes a counter-reset mode and a power-down on the same edge, then releases the mode while the power-down continues. It judges every cycle against a behavioural model.

A power-up write is also placed in the one cycle a channel spends in `PWR_TRI`. The model expects `PWR_ON` after that edge and no power-down at all.

Random traffic then mixes strobes on both channels, mode writes and lock changes, so that the same comparison covers these collisions in many more combinations.

// File: rtl/syn_pwr_pkg.sv
package syn_pwr_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_IF  = 0;
    localparam int CH_RF  = 1;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_TRI  = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_state_e;

    typedef enum logic [MODE_W-1:0] {
        MUX_LOW       = 3'd0,
        MUX_IF_LOCK   = 3'd1,
        MUX_RF_LOCK   = 3'd2,
        MUX_BOTH_LOCK = 3'd3,
        MUX_IF_CRST   = 3'd4,
        MUX_RF_CRST   = 3'd5,
        MUX_BOTH_CRST = 3'd6,
        MUX_FAST      = 3'd7
    } mux_mode_e;
endpackage

// File: rtl/chan_pwr_fsm.sv
module chan_pwr_fsm
    import syn_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic pd_bit_i,
    input  logic tri_bit_i,
    input  logic crst_i,
    input  logic gain_wr_i,
    input  logic gain_bit_i,
    output logic cp_tri_o,
    output logic pwr_down_o,
    output logic cp_max_o
);
    pwr_state_e state_q, state_d;
    logic       tri_q;
    logic       gain_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_DOWN;
            tri_q   <= 1'b0;
            gain_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_i)      tri_q  <= tri_bit_i;
            if (gain_wr_i) gain_q <= gain_bit_i;
        end
    end

    // next state: the route is chosen from the tristate bit stored before this write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ON: begin
                if (wr_i && pd_bit_i) state_d = tri_q ? PWR_DOWN : PWR_TRI;
            end
            PWR_TRI: begin
                if (wr_i && !pd_bit_i) state_d = PWR_ON;
                else                   state_d = PWR_DOWN;
            end
            PWR_DOWN: begin
                if (wr_i && !pd_bit_i) state_d = PWR_ON;
            end
            default: state_d = PWR_DOWN;
        endcase
    end

    // outputs
    always_comb begin
        cp_tri_o   = tri_q | crst_i;
        pwr_down_o = 1'b0;
        unique case (state_q)
            PWR_ON:   ;
            PWR_TRI:  cp_tri_o = 1'b1;
            PWR_DOWN: begin
                cp_tri_o   = 1'b1;
                pwr_down_o = 1'b1;
            end
            default:  pwr_down_o = 1'b1;
        endcase
        cp_max_o = gain_q;
    end

    AST_TRI_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down_o) |-> $past(cp_tri_o)); // R2
    AST_SYNC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ON && wr_i && pd_bit_i && !tri_q) |=> (state_q == PWR_TRI && !pwr_down_o)); // R2
    AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pd_bit_i && tri_q) |=> pwr_down_o); // R3
    AST_PWR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !pd_bit_i) |=> (state_q == PWR_ON)); // R4
endmodule

// File: rtl/mode_mux.sv
module mode_mux
    import syn_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_sel_i,
    input  logic [NUM_CH-1:0] lock_i,
    input  logic              fast_i,
    output logic [NUM_CH-1:0] crst_o,
    output logic              mux_o
);
    mux_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= MUX_LOW;
        else if (mode_wr_i) mode_q <= mux_mode_e'(mode_sel_i);
    end

    always_comb begin
        crst_o = '0;
        mux_o  = 1'b0;
        unique case (mode_q)
            MUX_LOW:       ;
            MUX_IF_LOCK:   mux_o = lock_i[CH_IF];
            MUX_RF_LOCK:   mux_o = lock_i[CH_RF];
            MUX_BOTH_LOCK: mux_o = lock_i[CH_IF] & lock_i[CH_RF];
            MUX_IF_CRST:   crst_o[CH_IF] = 1'b1;
            MUX_RF_CRST:   crst_o[CH_RF] = 1'b1;
            MUX_BOTH_CRST: crst_o = '1;
            MUX_FAST:      mux_o = fast_i;
            default:       ;
        endcase
    end

    AST_BOTH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MUX_BOTH_LOCK && mux_o) |-> (&lock_i)); // R8
    AST_CRST_MUX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|crst_o) |-> !mux_o); // R6
endmodule

// File: rtl/syn_chan_ctrl.sv
module syn_chan_ctrl
    import syn_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_wr,
    input  logic [1:0]  cfg_pd,
    input  logic [1:0]  cfg_tri,
    input  logic [1:0]  gain_wr,
    input  logic [1:0]  gain_bit,
    input  logic        mode_wr,
    input  logic [2:0]  mode_sel,
    input  logic [1:0]  lock_in,
    output logic [1:0]  cnt_rst,
    output logic [1:0]  div_load,
    output logic [1:0]  cp_tri,
    output logic [1:0]  cp_max,
    output logic [1:0]  debias,
    output logic        ref_osc_en,
    output logic        fl_sw,
    output logic        mux_out
);
    logic [NUM_CH-1:0] crst;
    logic [NUM_CH-1:0] pwr_down;

    mode_mux u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr_i  (mode_wr),
        .mode_sel_i (mode_sel),
        .lock_i     (lock_in),
        .fast_i     (cp_max[CH_RF]),
        .crst_o     (crst),
        .mux_o      (mux_out)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_pwr_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (cfg_wr[c]),
            .pd_bit_i   (cfg_pd[c]),
            .tri_bit_i  (cfg_tri[c]),
            .crst_i     (crst[c]),
            .gain_wr_i  (gain_wr[c]),
            .gain_bit_i (gain_bit[c]),
            .cp_tri_o   (cp_tri[c]),
            .pwr_down_o (pwr_down[c]),
            .cp_max_o   (cp_max[c])
        );

        AST_CRST_TRI: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_rst[c] |-> cp_tri[c]); // R6
    end

    assign cnt_rst    = crst;
    assign div_load   = pwr_down;
    assign debias     = pwr_down;
    assign ref_osc_en = ~(&pwr_down);
    assign fl_sw      = cp_max[CH_RF];

    AST_REF_RUNS_ONE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_load != 2'b11) |-> ref_osc_en); // R5
endmodule

// File: tb/tb_syn_chan_ctrl.sv
`timescale 1ns/1ps
module tb_syn_chan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_wr = '0, cfg_pd = '0, cfg_tri = '0, gain_wr = '0, gain_bit = '0, lock_in = '0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_sel = '0;
    logic [1:0] cnt_rst, div_load, cp_tri, cp_max, debias;
    logic       ref_osc_en, fl_sw, mux_out;

    always #10 clk = ~clk;

    syn_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pd(cfg_pd), .cfg_tri(cfg_tri),
        .gain_wr(gain_wr), .gain_bit(gain_bit), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .lock_in(lock_in), .cnt_rst(cnt_rst), .div_load(div_load), .cp_tri(cp_tri),
        .cp_max(cp_max), .debias(debias), .ref_osc_en(ref_osc_en), .fl_sw(fl_sw),
        .mux_out(mux_out)
    );

    int    n_run = 0, n_fail = 0;
    bit    chk_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // reference model: power step 0 = on, 1 = tristate step, 2 = down
    int ps[2];
    bit tri_m[2];
    bit gain_m[2];
    int md;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ps[i]) begin ps[i] = 2; tri_m[i] = 0; gain_m[i] = 0; end
            md = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (cfg_wr[c]) begin
                    if (!cfg_pd[c])   ps[c] = 0;
                    else if (ps[c] == 0) ps[c] = tri_m[c] ? 2 : 1;
                    else              ps[c] = 2;
                    tri_m[c] = cfg_tri[c];
                end else if (ps[c] == 1) begin
                    ps[c] = 2;
                end
                if (gain_wr[c]) gain_m[c] = gain_bit[c];
            end
            if (mode_wr) md = int'(mode_sel);
        end
    end

    task automatic chk(input string what, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %b expected %b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [1:0] e_crst, e_pd, e_tri, e_max;
            logic       e_mux;
            for (int c = 0; c < 2; c++) begin
                e_crst[c] = (md == 4 + c) || (md == 6);
                e_pd[c]   = (ps[c] == 2);
                e_tri[c]  = tri_m[c] || (ps[c] != 0) || e_crst[c];
                e_max[c]  = gain_m[c];
            end
            case (md)
                1: e_mux = lock_in[0];
                2: e_mux = lock_in[1];
                3: e_mux = lock_in[0] & lock_in[1];
                7: e_mux = gain_m[1];
                default: e_mux = 1'b0;
            endcase
            chk("cnt_rst", cnt_rst, e_crst);
            chk("div_load", div_load, e_pd);
            chk("debias", debias, e_pd);
            chk("cp_tri", cp_tri, e_tri);
            chk("cp_max", cp_max, e_max);
            chk("ref_osc_en", {1'b0, ref_osc_en}, {1'b0, !(e_pd[0] && e_pd[1])});
            chk("fl_sw", {1'b0, fl_sw}, {1'b0, gain_m[1]});
            chk("mux_out", {1'b0, mux_out}, {1'b0, e_mux});
        end
    end

    task automatic tick();
        @(negedge clk);
        #5;
    endtask

    task automatic cfg(input int c, input bit pd, input bit tr);
        cfg_wr[c] = 1'b1; cfg_pd[c] = pd; cfg_tri[c] = tr;
        tick();
        cfg_wr = '0;
    endtask

    task automatic set_mode(input int m);
        mode_wr = 1'b1; mode_sel = 3'(m);
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic set_gain(input int c, input bit g);
        gain_wr[c] = 1'b1; gain_bit[c] = g;
        tick();
        gain_wr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        chk_on = 1'b1;
        cur_req = "R1";
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        cur_req = "R4";                // power up both from reset state
        cfg(0, 0, 0); cfg(1, 0, 0); repeat (2) tick();

        cur_req = "R2";                // synchronous IF power-down
        cfg(0, 1, 0); repeat (3) tick();
        cur_req = "R5";                // one channel down: reference keeps running
        tick();

        cur_req = "R3";                // RF: store tristate, then power down at once
        cfg(1, 0, 1); tick(); cfg(1, 1, 1); repeat (2) tick();
        cur_req = "R5"; tick();

        cur_req = "R4";                // power-up write landing in the tristate step
        cfg(0, 0, 0); tick();
        cfg(0, 1, 0); cfg(0, 0, 0); repeat (3) tick();
        cfg(1, 0, 0); repeat (2) tick();

        cur_req = "R6";                // counter reset modes, overlapping a sync power-down
        set_mode(4); tick(); set_mode(5); tick(); set_mode(6); tick();
        mode_wr = 1'b1; mode_sel = 3'd4; cfg_wr[0] = 1'b1; cfg_pd[0] = 1'b1; cfg_tri[0] = 1'b0;
        tick(); mode_wr = 1'b0; cfg_wr = '0;
        set_mode(0); repeat (2) tick();
        cfg(0, 0, 0); tick();

        cur_req = "R7";                // fastlock gain bits
        set_gain(0, 1); set_gain(1, 1); set_mode(7); tick();
        set_gain(1, 0); tick(); set_gain(0, 0); tick();

        cur_req = "R8";                // lock-detect modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m);
            for (int l = 0; l < 4; l++) begin
                lock_in = 2'(l); tick();
            end
        end

        cur_req = "R9";                // one channel's writes leave the other alone
        cfg(1, 0, 1); cfg(0, 1, 0); repeat (2) tick(); cfg(0, 0, 0); tick();
        for (int i = 0; i < 400; i++) begin
            cfg_wr   = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            cfg_pd   = 2'($urandom_range(0, 3));
            cfg_tri  = 2'($urandom_range(0, 3));
            gain_wr  = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            gain_bit = 2'($urandom_range(0, 3));
            mode_wr  = ($urandom_range(0, 3) == 0);
            mode_sel = 3'($urandom_range(0, 7));
            lock_in  = 2'($urandom_range(0, 3));
            tick();
        end
        cfg_wr = '0; gain_wr = '0; mode_wr = 1'b0;
        repeat (3) tick();
        finish_run();
    end
endmodule